// File: doc/BRIEF.md
# Memory On-Die Termination Controller

This block is the termination-control path of a DDR3-style memory device. On every rising clock edge it registers an external termination request pin. The request is delayed by a latency of CWL + AL - 2 clock cycles, where CWL is the write latency and AL is the additive latency. The delayed request then drives an internal termination-enable output. The same latency applies when termination turns on and when it turns off.

Two conditions force termination off whatever the request pin does. The first is a nominal-termination setting code of zero. The second is the delay-locked loop being off or unlocked.

The block also checks the minimum-high rules on the request pin and flags any low that comes too early. After the pin is registered high, it must stay high for 4 cycles. A write command registered while the pin is high restarts that window with a length set by the burst length: 4 cycles for burst length 4 and 6 cycles for burst length 8. Latency settings that give a negative delay, or one deeper than the delay line, are clamped and flagged.

Top module: `odt_term_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the delay line and the hold tracking. While reset is asserted and in the cycle after it, `term_en` and `hold_viol` are 0.
- R2: With termination allowed, `term_en` rises CWL + AL - 2 rising edges after the edge that first registers `odt_in` high. `term_en` is registered, so it is first seen 1 after edge number CWL + AL - 1, counting the registering edge as 1.
- R3: `term_en` falls after the same number of edges once `odt_in` is registered low. The on and off latencies are equal, so a request pulse of N cycles gives N cycles of `term_en`.
- R4: When `rtt_code` equals 3'b000, `term_en` is 0 from the next edge onward, whatever `odt_in` does.
- R5: When `dll_locked` is 0, `term_en` is 0 from the next edge onward, whatever `odt_in` does.
- R6: Once `odt_in` is registered high, it must stay high at the next 3 edges. A low at edge k+4 or later, where k is the rising edge, is legal. An earlier low raises `hold_viol` after that edge.
- R7: A write command (`wr_cmd` = 1) registered at edge w while `odt_in` is high restarts the hold window. A low is legal from edge w+4 when `bl8_sel` = 0 (burst length 4) and from edge w+6 when `bl8_sel` = 1 (burst length 8). An earlier low raises `hold_viol`. A write registered while `odt_in` is low has no effect.
- R8: `hold_viol` is a pulse one cycle wide. A violation does not alter `term_en`, which still follows the delayed request.
- R9: When CWL + AL - 2 is below 0, the latency is clamped to 0. When it is above the delay-line depth (16 by default), it is clamped to 16. In both cases the combinational output `cfg_err` is 1; for in-range settings it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| odt_in | input | 1 | External termination request |
| wr_cmd | input | 1 | Write command registered this edge |
| bl8_sel | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| cwl | input | 4 | Write latency in cycles |
| al | input | 4 | Additive latency in cycles |
| rtt_code | input | 3 | Nominal-termination setting; 3'b000 disables |
| dll_locked | input | 1 | 1 when the delay-locked loop is on and locked |
| term_en | output | 1 | Internal termination enable |
| hold_viol | output | 1 | One-cycle pulse on an early request low |
| cfg_err | output | 1 | Latency setting was clamped |

## Verification
The bench measures on and off latency over several latency settings, including both clamp directions. An off-by-one tap would be seen as a latency one cycle long or short, and unequal on and off paths would stretch or shrink the termination pulse. Hold checks run at each window boundary, one cycle short and exactly legal, for the plain window and for write-restarted windows at both burst lengths. A counter off by one would flag a legal low or miss an illegal one. The gating tests hold the request high while the setting code is zero or the loop is unlocked, then release the gate. A design that gated at the input rather than the output would show a late turn-on after release.

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl #(
  parameter int DEPTH = 16,
  parameter int H4    = 4,
  parameter int H8    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       odt_in,
  input  logic       wr_cmd,
  input  logic       bl8_sel,
  input  logic [3:0] cwl,
  input  logic [3:0] al,
  input  logic [2:0] rtt_code,
  input  logic       dll_locked,
  output logic       term_en,
  output logic       hold_viol,
  output logic       cfg_err
);
  localparam int TW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int HW = $clog2(H8 + 1);

  logic [DEPTH-1:0] dly;
  int               lat_raw;
  logic [TW-1:0]    tap;
  logic [IW-1:0]    idx;
  logic             term_d, gate, odt_q;
  logic [HW-1:0]    rem, rem_dec, rem_wr, rem_restart;

  assign lat_raw = int'(cwl) + int'(al) - 2;
  assign cfg_err = (lat_raw < 0) || (lat_raw > DEPTH);
  assign tap     = (lat_raw < 0) ? '0 : (lat_raw > DEPTH) ? TW'(DEPTH) : TW'(lat_raw);
  assign idx     = IW'(tap - TW'(1));
  assign term_d  = (tap == '0) ? odt_in : dly[idx];
  assign gate    = dll_locked && (rtt_code != 3'b000);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly     <= '0;
      term_en <= 1'b0;
    end else begin
      dly     <= {dly[DEPTH-2:0], odt_in};
      term_en <= gate && term_d;
    end
  end

  assign rem_dec     = (rem == '0) ? '0 : rem - 1'b1;
  assign rem_wr      = bl8_sel ? HW'(H8 - 1) : HW'(H4 - 1);
  assign rem_restart = (rem_dec > rem_wr) ? rem_dec : rem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      odt_q     <= 1'b0;
      rem       <= '0;
      hold_viol <= 1'b0;
    end else begin
      odt_q     <= odt_in;
      hold_viol <= !odt_in && odt_q && (rem != '0);
      if (!odt_in)     rem <= '0;
      else if (wr_cmd) rem <= rem_restart;
      else if (!odt_q) rem <= HW'(H4 - 1);
      else             rem <= rem_dec;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!term_en && !hold_viol));
  p_rtt_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (rtt_code == 3'b000) |=> !term_en);
  p_dll_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !dll_locked |=> !term_en);
  p_viol_on_low_r6: assert property (@(posedge clk) disable iff (rst)
    hold_viol |-> !$past(odt_in));
  p_rem_bound_r7: assert property (@(posedge clk) disable iff (rst)
    rem <= HW'(H8 - 1));
  p_viol_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    hold_viol |=> !hold_viol);
  p_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (tap == '0 || tap == TW'(DEPTH)));
endmodule

// File: tb/odt_term_ctrl_tb.sv
`timescale 1ns/1ps
module odt_term_ctrl_tb;
  logic clk = 0, rst = 1, odt_in = 0, wr_cmd = 0, bl8_sel = 0, dll_locked = 1;
  logic [3:0] cwl = 4'd5, al = 4'd0;
  logic [2:0] rtt_code = 3'b001;
  logic term_en, hold_viol, cfg_err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  odt_term_ctrl u_dut (.clk, .rst, .odt_in, .wr_cmd, .bl8_sel, .cwl, .al,
    .rtt_code, .dll_locked, .term_en, .hold_viol, .cfg_err);

  localparam int NV = 5;
  localparam int VCWL[NV] = '{5, 6, 8, 1, 15};
  localparam int VAL [NV] = '{0, 5, 6, 0, 15};
  localparam int VLAT[NV] = '{4, 10, 13, 1, 17};
  localparam int VERR[NV] = '{0, 0, 0, 1, 1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    odt_in = 0; wr_cmd = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic hold_run(input int n, input int wr_at, input bit bl8,
                          input bit exp_viol, input string tag);
    int on_cnt = 0;
    bl8_sel = bl8;
    odt_in = 1;
    for (int i = 0; i < n; i++) begin
      wr_cmd = (i == wr_at);
      step();
      on_cnt += int'(term_en);
    end
    wr_cmd = 0; odt_in = 0;
    step();
    on_cnt += int'(term_en);
    check(hold_viol == exp_viol, tag, hold_viol, exp_viol);
    step();
    on_cnt += int'(term_en);
    check(hold_viol == 0, "R8 pulse width", hold_viol, 0);
    for (int i = 0; i < 12; i++) begin step(); on_cnt += int'(term_en); end
    check(on_cnt == n, "R8 enable follows request", on_cnt, n);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    odt_in = 1;
    for (int i = 0; i < 4; i++) step();
    check(term_en == 0 && hold_viol == 0, "R1 reset state", term_en, 0);
    odt_in = 0; rst = 0;
    idle(3);

    // R2/R3/R9 latency table
    for (int v = 0; v < NV; v++) begin
      int n;
      cwl = 4'(VCWL[v]); al = 4'(VAL[v]);
      #1;
      check(cfg_err == VERR[v][0], "R9 clamp flag", cfg_err, VERR[v]);
      idle(20);
      odt_in = 1; n = 0;
      do begin step(); n++; end while (!term_en && n < 40);
      check(n == VLAT[v], "R2 on latency", n, VLAT[v]);
      for (int i = 0; i < 4; i++) step();
      odt_in = 0; n = 0;
      do begin step(); n++; end while (term_en && n < 40);
      check(n == VLAT[v], "R3 off latency", n, VLAT[v]);
    end
    cwl = 4'd5; al = 4'd0;
    idle(20);

    // R6 plain hold window
    hold_run(3, -1, 0, 1, "R6 early low");
    hold_run(4, -1, 0, 0, "R6 legal low");
    // R7 write restart, write at edge k+2
    hold_run(5, 2, 0, 1, "R7 bl4 early");
    hold_run(6, 2, 0, 0, "R7 bl4 legal");
    hold_run(7, 2, 1, 1, "R7 bl8 early");
    hold_run(8, 2, 1, 0, "R7 bl8 legal");
    // R7 write while low has no effect
    wr_cmd = 1; step(); wr_cmd = 0; step();
    hold_run(4, -1, 1, 0, "R7 write while low ignored");

    // R4 code zero gating
    rtt_code = 3'b000; odt_in = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin step(); seen += int'(term_en); end
      check(seen == 0, "R4 code zero forces off", seen, 0);
    end
    rtt_code = 3'b011; step();
    check(term_en == 1, "R4 release gate", term_en, 1);
    // R5 loop unlocked gating
    dll_locked = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin step(); seen += int'(term_en); end
      check(seen == 0, "R5 unlocked forces off", seen, 0);
    end
    dll_locked = 1; step();
    check(term_en == 1, "R5 relock", term_en, 1);

    // R1 mid-run reset
    rst = 1; step();
    check(term_en == 0 && hold_viol == 0, "R1 reset mid-run", term_en, 0);
    rst = 0; odt_in = 0;
    idle(6);
    check(term_en == 0, "R1 line cleared", term_en, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule